// File: doc/BRIEF.md
# Posted Interrupt Descriptor Processor

This block handles a notification interrupt that targets a posted-interrupt descriptor. The descriptor is 512 bits wide. Its low 256 bits hold one request flag per interrupt vector. Bit 256 records that a notification is outstanding, and the bits above it are free for other use. When posted processing is enabled and the incoming vector equals the configured notification vector, the block runs a fixed sequence over several clock cycles:

- It clears the outstanding flag.
- It sends a one-cycle end-of-interrupt pulse to the physical interrupt controller.
- It reads and zeroes the request flags.
- It merges those flags into the virtual interrupt request register (virtual IRR), one 32-bit word per cycle.
- It finds the highest pending vector and raises the requesting-vector register (RVI) to that value when it is at least as high as the current RVI.
- It re-evaluates whether a virtual interrupt is pending for the delivery engine.

For testing, the descriptor, the virtual IRR and RVI are held in local registers that a load port can seed while the block is idle. The sequence itself is not restartable. While it runs, the busy output is high, and any new notification or load is ignored.

Top module: `pidesc_proc`

## Requirements
- R1: After reset, busy, accepted, eoi_pulse, done and pend_out are 0, and desc_out, virr_out and rvi_out are all zero.
- R2: A notification is rejected when post_en is 0 or when notify_vec differs from cfg_vec. A rejected notification leaves accepted and busy at 0, and leaves the descriptor, virtual IRR, RVI and pending flag unchanged.
- R3: On an accepted notification sampled at clock edge E0, accepted is high for exactly the one cycle after E0 and busy is high from E0 until done. A notification arriving while busy is ignored.
- R4: Bit 256 of the descriptor reads 0 one cycle after the accepted pulse, before the end-of-interrupt pulse is issued.
- R5: eoi_pulse is high for exactly one cycle, the second cycle after the accepted pulse.
- R6: The request bits [255:0] of the descriptor read zero from the third cycle after the accepted pulse. Bits [511:257] are never altered by processing.
- R7: At completion, virtual IRR equals its old value ORed with the old request bits. Vector v sits at bit v, and word w covers vectors 32w to 32w+31.
- R8: At completion, RVI is replaced by the highest set vector of the merged virtual IRR when that vector is greater than or equal to RVI. An empty IRR yields vector 0, so RVI never decreases.
- R9: At completion, pend_out equals 1 exactly when win_blk is 0 and RVI bits [7:4] exceed vppr bits [7:4]. A load clears pend_out.
- R10: done pulses for one cycle 13 cycles after the accepted pulse, when busy falls. A load presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Seeds descriptor, virtual IRR and RVI when idle |
| load_desc | input | 512 | Descriptor seed value |
| load_virr | input | 256 | Virtual IRR seed value |
| load_rvi | input | 8 | RVI seed value |
| notify_valid | input | 1 | Notification interrupt arrives |
| notify_vec | input | 8 | Vector of the notification |
| cfg_vec | input | 8 | Configured notification vector |
| post_en | input | 1 | Posted processing enable |
| vppr | input | 8 | Virtual processor priority used for pending evaluation |
| win_blk | input | 1 | Blocks the pending flag when high |
| busy | output | 1 | Sequence in progress |
| accepted | output | 1 | One-cycle pulse on acceptance |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt to the physical controller |
| done | output | 1 | One-cycle pulse at completion |
| desc_out | output | 512 | Current descriptor contents |
| virr_out | output | 256 | Virtual IRR |
| rvi_out | output | 8 | Requesting virtual interrupt |
| pend_out | output | 1 | Virtual interrupt pending |

## Verification
Counting from the edge E0 that samples an accepted notification, results come due at these times:
- accepted is due in the cycle right after E0.
- The cleared outstanding bit is due one cycle later.
- eoi_pulse is due two cycles after E0.
- The zeroed request bits are due three cycles after E0.
- The merged virtual IRR, the new RVI, the pending flag and done are due 13 cycles after E0.

The bench drives inputs and samples outputs on falling edges and counts those edges from E0, so each check lands in exactly the cycle its result is due. At the fourth falling edge, in the middle of every sequence, it injects a matching notification and a load of junk values, and both must leave the final results untouched.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int PID_NUM_VEC = 256;
    localparam int PID_WORD_W  = 32;
    localparam int PID_DESC_W  = 512;
    localparam int PID_CLASS_LSB = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR_ON,
        ST_EOI,
        ST_GRAB,
        ST_MERGE,
        ST_SCAN,
        ST_EVAL
    } pid_state_e;

    typedef struct packed {
        logic acc;
        logic eoi;
        logic done;
    } pid_pulse_t;

    // pending when the RVI priority class is above the processor priority class
    function automatic logic pid_pend_eval(input logic [7:0] rvi,
                                           input logic [7:0] ppr,
                                           input logic       blk);
        return !blk && (rvi[7:PID_CLASS_LSB] > ppr[7:PID_CLASS_LSB]);
    endfunction

endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
    import pid_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output pid_state_e       state,
    output logic [IDX_W-1:0] word_idx,
    output pid_pulse_t       pulses,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    pid_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    pid_pulse_t       pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pulse_q <= '0;
        end else begin
            pulse_q.acc  <= (state_q == ST_IDLE) && go;
            pulse_q.eoi  <= (state_q == ST_EOI);
            pulse_q.done <= (state_q == ST_EVAL);
            case (state_q)
                ST_IDLE:   if (go) state_q <= ST_CLR_ON;
                ST_CLR_ON: state_q <= ST_EOI;
                ST_EOI:    state_q <= ST_GRAB;
                ST_GRAB: begin
                    idx_q   <= '0;
                    state_q <= ST_MERGE;
                end
                ST_MERGE: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_SCAN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_SCAN:   state_q <= ST_EVAL;
                ST_EVAL:   state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign state    = state_q;
    assign word_idx = idx_q;
    assign pulses   = pulse_q;
    assign busy     = (state_q != ST_IDLE);

    AST_ACC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_q.acc |=> !pulse_q.acc); // R3
    AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_q.eoi |=> !pulse_q.eoi); // R5
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        pulse_q.done |-> (state_q == ST_IDLE)); // R10
    AST_ACC_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        pulse_q.acc |-> (state_q == ST_CLR_ON)); // R3

endmodule

// File: rtl/pid_virr.sv
module pid_virr #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [NUM_VEC-1:0] load_val,
    input  logic               merge_en,
    input  logic [IDX_W-1:0]   merge_idx,
    input  logic [WORD_W-1:0]  merge_word,
    output logic [NUM_VEC-1:0] virr
);

    logic [WORD_W-1:0] words_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[w] <= '0;
            end else if (load) begin
                words_q[w] <= load_val[w*WORD_W +: WORD_W];
            end else if (merge_en && (merge_idx == IDX_W'(w))) begin
                words_q[w] <= words_q[w] | merge_word;
            end
        end
        assign virr[w*WORD_W +: WORD_W] = words_q[w];
    end

    AST_VIRR_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ((virr & $past(virr)) == $past(virr))); // R7

endmodule

// File: rtl/pid_prio.sv
module pid_prio #(
    parameter int NUM_VEC = 256,
    localparam int VEC_W = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] vec_set,
    output logic [VEC_W-1:0]   top_vec,
    output logic               any_set
);

    always_comb begin
        top_vec = '0;
        any_set = 1'b0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (vec_set[i]) begin
                top_vec = VEC_W'(i);
                any_set = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pidesc_proc.sv
module pidesc_proc
    import pid_pkg::*;
#(
    parameter int NUM_VEC = PID_NUM_VEC,
    parameter int WORD_W  = PID_WORD_W,
    parameter int DESC_W  = PID_DESC_W,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int ON_BIT    = NUM_VEC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DESC_W-1:0] load_desc,
    input  logic [NUM_VEC-1:0] load_virr,
    input  logic [VEC_W-1:0]  load_rvi,
    input  logic              notify_valid,
    input  logic [VEC_W-1:0]  notify_vec,
    input  logic [VEC_W-1:0]  cfg_vec,
    input  logic              post_en,
    input  logic [VEC_W-1:0]  vppr,
    input  logic              win_blk,
    output logic              busy,
    output logic              accepted,
    output logic              eoi_pulse,
    output logic              done,
    output logic [DESC_W-1:0] desc_out,
    output logic [NUM_VEC-1:0] virr_out,
    output logic [VEC_W-1:0]  rvi_out,
    output logic              pend_out
);

    pid_state_e        state;
    logic [IDX_W-1:0]  word_idx;
    pid_pulse_t        pulses;
    logic              busy_w;
    logic              go;
    logic              load_go;
    logic [DESC_W-1:0] desc_q;
    logic [NUM_VEC-1:0] snap_q;
    logic [VEC_W-1:0]  rvi_q;
    logic              pend_q;
    logic [NUM_VEC-1:0] virr_w;
    logic [VEC_W-1:0]  top_vec;
    logic              any_set;
    logic [WORD_W-1:0] merge_word;

    assign go      = notify_valid && post_en && (notify_vec == cfg_vec) && !busy_w;
    assign load_go = load_en && !busy_w;

    pid_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .state    (state),
        .word_idx (word_idx),
        .pulses   (pulses),
        .busy     (busy_w)
    );

    // descriptor: clear outstanding flag, then read-and-clear request bits
    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
            snap_q <= '0;
        end else if (load_go) begin
            desc_q <= load_desc;
        end else if (state == ST_CLR_ON) begin
            desc_q[ON_BIT] <= 1'b0;
        end else if (state == ST_GRAB) begin
            snap_q              <= desc_q[NUM_VEC-1:0];
            desc_q[NUM_VEC-1:0] <= '0;
        end
    end

    assign merge_word = snap_q[word_idx*WORD_W +: WORD_W];

    pid_virr #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_virr (
        .clk        (clk),
        .rst        (rst),
        .load       (load_go),
        .load_val   (load_virr),
        .merge_en   (state == ST_MERGE),
        .merge_idx  (word_idx),
        .merge_word (merge_word),
        .virr       (virr_w)
    );

    pid_prio #(.NUM_VEC(NUM_VEC)) u_prio (
        .vec_set (virr_w),
        .top_vec (top_vec),
        .any_set (any_set)
    );

    // RVI only rises; an empty IRR reports vector 0
    always_ff @(posedge clk) begin
        if (rst) begin
            rvi_q  <= '0;
            pend_q <= 1'b0;
        end else if (load_go) begin
            rvi_q  <= load_rvi;
            pend_q <= 1'b0;
        end else begin
            if ((state == ST_SCAN) && (top_vec >= rvi_q)) begin
                rvi_q <= any_set ? top_vec : '0;
            end
            if (state == ST_EVAL) begin
                pend_q <= pid_pend_eval(rvi_q, vppr, win_blk);
            end
        end
    end

    assign busy      = busy_w;
    assign accepted  = pulses.acc;
    assign eoi_pulse = pulses.eoi;
    assign done      = pulses.done;
    assign desc_out  = desc_q;
    assign virr_out  = virr_w;
    assign rvi_out   = rvi_q;
    assign pend_out  = pend_q;

    AST_ON_BEFORE_EOI: assert property (@(posedge clk) disable iff (rst)
        pulses.eoi |-> !desc_q[ON_BIT]); // R4
    AST_FREE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !$past(load_go) |-> (desc_q[DESC_W-1:ON_BIT+1] == $past(desc_q[DESC_W-1:ON_BIT+1]))); // R6
    AST_RVI_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !$past(load_go) |-> (rvi_q >= $past(rvi_q))); // R8
    AST_PIR_ZERO_AT_MERGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MERGE) |-> (desc_q[NUM_VEC-1:0] == '0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy_w) && !$past(load_go) && !busy_w) |-> ($stable(rvi_q) && $stable(pend_q))); // R2

endmodule

// File: tb/pidesc_proc_tb.sv
module pidesc_proc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_en;
    logic [511:0] load_desc;
    logic [255:0] load_virr;
    logic [7:0]   load_rvi;
    logic         notify_valid;
    logic [7:0]   notify_vec;
    logic [7:0]   cfg_vec;
    logic         post_en;
    logic [7:0]   vppr;
    logic         win_blk;
    logic         busy, accepted, eoi_pulse, done, pend_out;
    logic [511:0] desc_out;
    logic [255:0] virr_out;
    logic [7:0]   rvi_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [511:0] m_desc;
    logic [255:0] m_virr;
    logic [7:0]   m_rvi;
    logic         m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    pidesc_proc u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_desc(load_desc),
        .load_virr(load_virr), .load_rvi(load_rvi), .notify_valid(notify_valid),
        .notify_vec(notify_vec), .cfg_vec(cfg_vec), .post_en(post_en),
        .vppr(vppr), .win_blk(win_blk), .busy(busy), .accepted(accepted),
        .eoi_pulse(eoi_pulse), .done(done), .desc_out(desc_out),
        .virr_out(virr_out), .rvi_out(rvi_out), .pend_out(pend_out)
    );

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] top_vec(input logic [255:0] v);
        logic [7:0] r = 8'd0;
        for (int i = 0; i < 256; i++) if (v[i]) r = 8'(i);
        return r;
    endfunction

    function automatic logic pend_model(input logic [7:0] r, input logic [7:0] p, input logic b);
        return !b && (r[7:4] > p[7:4]);
    endfunction

    function automatic logic [255:0] rand256(input int sparsity);
        logic [255:0] v = '0;
        for (int w = 0; w < 8; w++) begin
            logic [31:0] x = $urandom;
            for (int s = 0; s < sparsity; s++) x = x & $urandom;
            v[w*32 +: 32] = x;
        end
        return v;
    endfunction

    task automatic do_load(input logic [511:0] d, input logic [255:0] v, input logic [7:0] r);
        load_en = 1'b1; load_desc = d; load_virr = v; load_rvi = r;
        @(negedge clk);
        load_en = 1'b0;
        m_desc = d; m_virr = v; m_rvi = r; m_pend = 1'b0;
    endtask

    task automatic run(input logic en, input logic [7:0] vec, input logic [7:0] cfg,
                       input logic [7:0] pp, input logic wb);
        logic [255:0] exp_virr;
        logic [7:0]   hv, exp_rvi;
        post_en = en; notify_vec = vec; cfg_vec = cfg; vppr = pp; win_blk = wb;
        notify_valid = 1'b1;
        @(negedge clk);
        notify_valid = 1'b0;
        if (!(en && vec == cfg)) begin
            chk("R2 accepted", 512'(accepted), 512'd0);
            chk("R2 busy", 512'(busy), 512'd0);
            @(negedge clk);
            chk("R2 desc", desc_out, m_desc);
            chk("R2 virr", 512'(virr_out), 512'(m_virr));
            chk("R2 rvi", 512'(rvi_out), 512'(m_rvi));
            chk("R2 pend", 512'(pend_out), 512'(m_pend));
            return;
        end
        chk("R3 accepted", 512'(accepted), 512'd1);
        chk("R3 busy", 512'(busy), 512'd1);
        @(negedge clk); // k=1
        chk("R4 on bit", 512'(desc_out[256]), 512'd0);
        chk("R5 eoi early", 512'(eoi_pulse), 512'd0);
        @(negedge clk); // k=2
        chk("R5 eoi", 512'(eoi_pulse), 512'd1);
        @(negedge clk); // k=3
        chk("R5 eoi single", 512'(eoi_pulse), 512'd0);
        chk("R6 pir zero", 512'(desc_out[255:0]), 512'd0);
        chk("R6 free bits", 512'(desc_out[511:257]), 512'(m_desc[511:257]));
        @(negedge clk); // k=4: inject while busy
        notify_valid = 1'b1;
        load_en = 1'b1; load_desc = {512{1'b1}}; load_virr = {256{1'b1}}; load_rvi = 8'hFF;
        @(negedge clk); // k=5
        notify_valid = 1'b0; load_en = 1'b0;
        chk("R3 no re-accept", 512'(accepted), 512'd0);
        for (int k = 6; k <= 13; k++) begin
            @(negedge clk);
            if (k == 12) begin
                chk("R10 done early", 512'(done), 512'd0);
                chk("R3 busy held", 512'(busy), 512'd1);
            end
        end
        exp_virr = m_virr | m_desc[255:0];
        hv = top_vec(exp_virr);
        exp_rvi = (hv >= m_rvi) ? hv : m_rvi;
        m_desc = {m_desc[511:257], 1'b0, 256'd0};
        m_virr = exp_virr; m_rvi = exp_rvi;
        m_pend = pend_model(exp_rvi, pp, wb);
        chk("R10 done", 512'(done), 512'd1);
        chk("R10 busy low", 512'(busy), 512'd0);
        chk("R7 virr", 512'(virr_out), 512'(exp_virr));
        chk("R8 rvi", 512'(rvi_out), 512'(exp_rvi));
        chk("R9 pend", 512'(pend_out), 512'(m_pend));
        chk("R6 desc", desc_out, m_desc);
        @(negedge clk);
        chk("R10 done single", 512'(done), 512'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [511:0] d;
        logic [7:0]   v8;
        void'($urandom(32'd20240127));
        rst = 1'b1; load_en = 1'b0; load_desc = '0; load_virr = '0; load_rvi = '0;
        notify_valid = 1'b0; notify_vec = '0; cfg_vec = 8'hF2; post_en = 1'b0;
        vppr = '0; win_blk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 512'(busy), 512'd0);
        chk("R1 pulses", 512'({accepted, eoi_pulse, done, pend_out}), 512'd0);
        chk("R1 desc", desc_out, 512'd0);
        chk("R1 virr", 512'(virr_out), 512'd0);
        chk("R1 rvi", 512'(rvi_out), 512'd0);

        // R2 rejections, then accept with rvi rising
        d = '0; d[511:257] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 31'h1ABC};
        d[256] = 1'b1; d[200] = 1'b1; d[5] = 1'b1;
        do_load(d, 256'd1 << 40, 8'd100);
        run(1'b0, 8'hF2, 8'hF2, 8'h30, 1'b0);
        run(1'b1, 8'hF3, 8'hF2, 8'h30, 1'b0);
        run(1'b1, 8'hF2, 8'hF2, 8'h30, 1'b0);

        // R8 empty request and IRR: rvi unchanged
        do_load({255'd7, 1'b1, 256'd0}, 256'd0, 8'h55);
        run(1'b1, 8'h41, 8'h41, 8'h60, 1'b0);
        // R8 equal vector, R9 window block
        do_load({255'd0, 1'b1, 256'd1 << 8'h55}, 256'd0, 8'h55);
        run(1'b1, 8'h41, 8'h41, 8'h10, 1'b1);
        // R8 lower vector keeps rvi
        do_load({255'd3, 1'b0, 256'd1 << 20}, 256'd1 << 16, 8'h90);
        run(1'b1, 8'h22, 8'h22, 8'h00, 1'b0);
        // R7 vector 255 and word boundaries
        do_load({255'd0, 1'b1, (256'd1 << 255) | (256'd1 << 32) | (256'd1 << 31)}, 256'd1, 8'd0);
        run(1'b1, 8'h22, 8'h22, 8'hE0, 1'b0);

        // constrained random
        for (int it = 0; it < 24; it++) begin
            d[255:0]   = (it % 5 == 0) ? 256'd0 : rand256(4);
            d[256]     = 1'($urandom);
            d[511:257] = {rand256(0), 255'(0)} >> 256;
            d[511:257] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 31'($urandom)};
            v8 = 8'($urandom);
            do_load(d, rand256(5), v8);
            if (($urandom % 5) == 0)
                run(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'(($urandom % 4) == 0));
            else
                run(1'b1, 8'hC7, 8'hC7, 8'($urandom), 1'(($urandom % 4) == 0));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule